// File: doc/BRIEF.md
# Serial Lane Packer with Longitudinal Checksum

This block turns a stream of parallel converter results from one group of columns into a two-bit-per-cycle serial stream for a single differential output lane. Each cycle it emits a pair of bits. The upper bit of the pair goes out on the rising half of the link clock and the lower bit on the falling half, so the pair models a double-data-rate lane. A full sensor instantiates one packer per lane, and each packer serves its own column group.

Each frame has three parts. It opens with a sync word that lets the receiver find word alignment. A fixed number of payload words follow, fetched from the column registers through a valid/ready handshake. The frame closes with a checksum word, which is the bitwise XOR of that frame's payload words. The checksum is built as words are accepted, so it is ready the moment the last payload word has gone out. When no frame is pending, the lane repeats an idle word that can never be mistaken for the sync word. Every word is sent most significant bit first.

Top module: `lvds_lane_packer`

## Requirements
- R1: While reset is held, `in_ready` is 0 and the lane shows the first pair of the idle word. After reset is released, `in_ready` stays 0 and the lane keeps showing the idle word until a frame starts. With the defaults the idle word is 16'h5555, so the first pair is 2'b01.
- R2: While `in_valid` is low, the lane repeats the idle word continuously and `in_ready` stays 0. After a frame's checksum word, the lane returns to idle words if no new frame is waiting.
- R3: A frame starts at the first word boundary at which `in_valid` is high. It begins with the sync word (default 16'hF20D). This word consumes no input.
- R4: Every word is sent as W/2 pairs, most significant bit first. `lane_d[1]` carries the earlier bit of each pair and `lane_d[0]` the later one.
- R5: A word is transferred on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in the last cycle of a sync or payload word slot, and only while the frame still needs payload. Exactly NWORDS words are accepted per frame, in order.
- R6: If `in_valid` is low when a payload slot begins, the packer sends one idle word in that slot. The idle word does not count as payload, and the frame continues with the next accepted word.
- R7: Directly after the last payload word, the packer sends a checksum word equal to the bitwise XOR of all of that frame's payload words.
- R8: The checksum restarts at every sync word, so it covers only the current frame.
- R9: If `in_valid` is high when a checksum word ends, the next frame's sync word follows with no idle word in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parallel word offered |
| in_data | input | W | Parallel word from the column registers |
| in_ready | output | 1 | Packer takes the offered word at this edge |
| lane_d | output | 2 | Bit pair for this cycle; bit 1 goes first |

## Verification
Four corner cases are targeted.

The first is a pause in the source mid-frame. A design that shifted stale data instead of an idle word, or counted the idle slot as payload, would corrupt or shorten the frame.

The second is back-to-back frames with valid held across the checksum. This catches a packer that inserts an idle word between frames. It also catches a checksum that is not cleared at sync, because the second frame's checksum would then include the first frame's words.

The third is the number of handshakes per frame. Any deviation from exactly NWORDS exposes a handshake that is raised during the sync or checksum slots.

The fourth is the reset state and the idle stream. A design with the wrong bit order or the wrong pair order would show a bit-reversed idle or sync word.

// File: rtl/lvds_lane_packer.sv
module lvds_lane_packer #(
  parameter int W = 16,
  parameter int NWORDS = 8,
  parameter logic [W-1:0] SYNC_WORD = 16'hF20D,
  parameter logic [W-1:0] IDLE_WORD = 16'h5555
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic [1:0]   lane_d
);
  localparam int HALF = W / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int WCW = $clog2(NWORDS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA, ST_LRC} st_t;

  st_t            st;
  logic [W-1:0]   sreg;
  logic [W-1:0]   lrc;
  logic [CW-1:0]  cnt;
  logic [WCW-1:0] wcnt;
  logic           last;
  logic           full;

  assign last     = (cnt == CW'(HALF - 1));
  assign full     = (wcnt == WCW'(NWORDS));
  assign in_ready = last && ((st == ST_SYNC) || (st == ST_DATA && !full));
  assign lane_d   = sreg[W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sreg <= IDLE_WORD;
      lrc  <= '0;
      cnt  <= '0;
      wcnt <= '0;
    end else if (!last) begin
      sreg <= sreg << 2;
      cnt  <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (st)
        ST_IDLE, ST_LRC: begin
          if (in_valid) begin
            st   <= ST_SYNC;
            sreg <= SYNC_WORD;
            lrc  <= '0;
            wcnt <= '0;
          end else begin
            st   <= ST_IDLE;
            sreg <= IDLE_WORD;
          end
        end
        default: begin
          if (st == ST_DATA && full) begin
            st   <= ST_LRC;
            sreg <= lrc;
          end else if (in_valid) begin
            st   <= ST_DATA;
            sreg <= in_data;
            lrc  <= lrc ^ in_data;
            wcnt <= wcnt + 1'b1;
          end else begin
            st   <= ST_DATA;
            sreg <= IDLE_WORD;
          end
        end
      endcase
    end
  end

  p_ready_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (st == ST_SYNC || st == ST_DATA));

  p_wcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WCW'(NWORDS));

  p_sync_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC && cnt == '0) |-> (sreg == SYNC_WORD));

  p_lrc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC) |-> (lrc == '0));

  p_lrc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LRC && cnt == '0) |-> (sreg == lrc));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cnt == '0) |-> (sreg == IDLE_WORD));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (sreg[W-1:2] == $past(sreg[W-3:0])));
endmodule

// File: tb/lvds_lane_packer_tb_top.sv
module lvds_lane_packer_tb_top;
  localparam int W = 16;
  localparam int NW = 8;
  localparam int HALF = W / 2;
  localparam logic [15:0] SYNC = 16'hF20D;
  localparam logic [15:0] IDLE = 16'h5555;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready;
  logic [1:0] lane_d;

  int tests = 0;
  int fails = 0;
  int xfers = 0;
  logic [15:0] pay [2][NW];

  lvds_lane_packer #(.W(W), .NWORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .lane_d(lane_d)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (in_valid && in_ready) xfers <= xfers + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int f, input int seed);
    for (int i = 0; i < NW; i++) begin
      pay[f][i] = 16'(seed * 16'h3B1 + i * 16'h1F3D) ^ 16'hA0C3;
      if (pay[f][i] == IDLE || pay[f][i] == SYNC) pay[f][i] = pay[f][i] ^ 16'h0100;
    end
  endtask

  task automatic get_word(output logic [15:0] w);
    w = '0;
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      w = {w[13:0], lane_d};
    end
  endtask

  task automatic wait_sync(output bit found);
    logic [15:0] h;
    h = '0;
    found = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      h = {h[13:0], lane_d};
      if (h == SYNC) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic drive_frame(input int f, input int gap_at, input bit hold);
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = pay[f][i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (i == gap_at) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2 * HALF) @(negedge clk);
      end
    end
    if (!hold) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic recv_frame(input int f, input bit immediate, input bit skip_idle, output int idles);
    logic [15:0] w;
    logic [15:0] exp_lrc;
    bit found;
    idles = 0;
    if (immediate) begin
      get_word(w);
      check(w == SYNC, "R9 sync follows checksum directly", 32'(w), 32'(SYNC));
    end else begin
      wait_sync(found);
      check(found, "R3 sync word seen", 32'(found), 32'd1);
    end
    exp_lrc = '0;
    for (int i = 0; i < NW; i++) begin
      get_word(w);
      if (skip_idle) begin
        for (int k = 0; k < 10 && w == IDLE; k++) begin
          idles++;
          get_word(w);
        end
      end
      check(w == pay[f][i], "R4 payload word", 32'(w), 32'(pay[f][i]));
      exp_lrc = exp_lrc ^ pay[f][i];
    end
    get_word(w);
    check(w == exp_lrc, "R7 R8 checksum word", 32'(w), 32'(exp_lrc));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R1 ready low in reset", 32'(in_ready), 32'd0);
    check(lane_d == 2'b01, "R1 idle pair in reset", 32'(lane_d), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(lane_d == 2'b01 && in_ready == 1'b0, "R1 idle after release", 32'({in_ready, lane_d}), 32'd1);
  endtask

  task automatic t_idle;
    logic [15:0] w;
    bit rdy_seen;
    rdy_seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      w = '0;
      for (int i = 0; i < HALF; i++) begin
        @(negedge clk);
        w = {w[13:0], lane_d};
        if (in_ready) rdy_seen = 1'b1;
      end
      check(w == IDLE, "R2 idle word repeats", 32'(w), 32'(IDLE));
    end
    check(!rdy_seen, "R2 ready stays low while idle", 32'(rdy_seen), 32'd0);
  endtask

  task automatic t_single;
    int x0;
    int idles;
    logic [15:0] w;
    fill(0, 1);
    x0 = xfers;
    fork
      drive_frame(0, -1, 1'b0);
      recv_frame(0, 1'b0, 1'b0, idles);
    join
    check(xfers - x0 == NW, "R5 words accepted per frame", 32'(xfers - x0), 32'(NW));
    get_word(w);
    check(w == IDLE, "R2 idle after checksum", 32'(w), 32'(IDLE));
  endtask

  task automatic t_back_to_back;
    int x0;
    int idles;
    fill(0, 7);
    fill(1, 23);
    x0 = xfers;
    fork
      begin
        drive_frame(0, -1, 1'b1);
        drive_frame(1, -1, 1'b0);
      end
      begin
        recv_frame(0, 1'b0, 1'b0, idles);
        recv_frame(1, 1'b1, 1'b0, idles);
      end
    join
    check(xfers - x0 == 2 * NW, "R5 words accepted over two frames", 32'(xfers - x0), 32'(2 * NW));
  endtask

  task automatic t_underrun;
    int x0;
    int idles;
    fill(0, 41);
    x0 = xfers;
    fork
      drive_frame(0, 3, 1'b0);
      recv_frame(0, 1'b0, 1'b1, idles);
    join
    check(idles >= 1, "R6 idle word fills missing slot", 32'(idles), 32'd1);
    check(xfers - x0 == NW, "R6 idle slot not counted", 32'(xfers - x0), 32'(NW));
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_idle;
        t_single;
        t_back_to_back;
        t_underrun;
        t_idle;
      end
      begin
        repeat (50000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule